// File: doc/BRIEF.md
# NAND Two-Phase Access Sequencer

This block turns single accesses from a host into bus cycles on a NAND flash device. Everything that shapes a flash operation is packed into the access address, so the block needs no control registers. Bit 19 of the address picks the kind of access. A command access sends a start opcode, then zero to seven address bytes, then an optional closing opcode. A data access moves one byte out of the device or into it. It may then send a closing opcode and may drop chip enable.

The host port is a valid/ready handshake. It carries a 32-bit address, a 32-bit write word and a direction bit. Read bytes come back on a one-cycle response pulse. Each data byte is also offered to a neighbouring error-correction engine, together with a flag that marks the final covered transfer. After every closing opcode the block waits for the device's ready line before it takes new work. A timeout counter bounds that wait.

Top module: `nand_phase_seq`

## Requirements
- R1: After reset every chip-enable output is high, both strobes are high, the command-latch and address-latch outputs are low, and `req_ready` is high.
- R2: An access with address bit 19 clear is a command access. Its first flash cycle is a write strobe with `nand_cle` high, carrying address bits 10:3 as the opcode.
- R3: In a command access, address bits 23:21 give the number of address bytes (0 to 7). These bytes follow the start opcode as write strobes with `nand_ale` high. They are taken from the write word least significant byte first.
- R4: When more than four address bytes are requested, the block raises `req_ready` again after the fourth byte. It takes a second write word and sends the remaining bytes from that word, again least significant byte first.
- R5: In either kind of access, when address bit 20 is set, a closing opcode from address bits 18:11 is sent last as a write strobe with `nand_cle` high.
- R6: An access with bit 19 set is a data access. A write sends `req_wdata[7:0]` with one write strobe and `nand_io_oe` high. A read makes one read strobe and returns the byte sampled from `nand_io_in` on `rsp_rdata` with a one-cycle `rsp_valid`.
- R7: The value of address bits 25:24 selects which of the four chip enables goes low, and at most one is low at a time. Chip enable stays low after an access unless the access is a data access with address bit 21 set. In that case all chip enables go high once that access completes.
- R8: Every data byte is presented on `ecc_byte` with a one-cycle `ecc_valid`. `ecc_last` is high in that cycle exactly when address bit 10 of the data access was set.
- R9: Each strobe stays low for `T_LOW` clocks and high for at least `T_HIGH` clocks. The command latch, address latch and driven data are stable for at least one clock before the strobe falls.
- R10: After a closing opcode the block keeps `req_ready` low until `nand_rdy` is high. If `nand_rdy` stays low for `TIMEOUT` clocks of waiting, it pulses `busy_timeout` and returns to idle.
- R11: An access that sends no closing opcode does not wait on `nand_rdy`. The block returns to idle even while `nand_rdy` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Host access request |
| req_ready | output | 1 | Block accepts an access or a second address word |
| req_write | input | 1 | 1 = write, 0 = read (data accesses) |
| req_addr | input | 32 | Encoded access address |
| req_wdata | input | 32 | Address bytes or write byte in [7:0] |
| rsp_valid | output | 1 | Read byte valid pulse |
| rsp_rdata | output | 8 | Read byte |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_ce_n | output | NUM_CE | Active-low chip enables |
| nand_we_n | output | 1 | Active-low write strobe |
| nand_re_n | output | 1 | Active-low read strobe |
| nand_io_out | output | 8 | Byte driven to the flash |
| nand_io_oe | output | 1 | Drive enable for nand_io_out |
| nand_io_in | input | 8 | Byte from the flash |
| nand_rdy | input | 1 | Ready (1) / busy (0) from the flash |
| ecc_valid | output | 1 | Data byte pulse for the correction engine |
| ecc_byte | output | 8 | Data byte |
| ecc_last | output | 1 | Marks the final covered byte |
| busy_timeout | output | 1 | Pulse when the ready wait expires |

## Verification
The hardest case to reach from the ports is the spill into a second write word. The sequencer must stop in the middle of an address run and reopen the host port. The stimulus table holds command accesses with five and seven address bytes. The bench sends a second word as soon as `req_ready` rises again, then compares every logged strobe against bytes taken from both words. The ready-wait timeout is reached by holding `nand_rdy` low across a closing opcode and measuring how long the port stays closed.

// File: rtl/nand_seq_pkg.sv
package nand_seq_pkg;

    localparam int ADDR_W    = 32;
    localparam int PHASE_BIT = 19;
    localparam int ENDV_BIT  = 20;
    localparam int REL_BIT   = 21;
    localparam int LAST_BIT  = 10;
    localparam int CHIP_LSB  = 24;

    typedef enum logic [2:0] {
        S_IDLE, S_START, S_ADDR, S_WORD2, S_DATA, S_END, S_BUSY, S_FIN
    } seq_state_t;

    typedef enum logic [1:0] {
        T_IDLE, T_SETUP, T_LOW, T_HIGH
    } strobe_phase_t;

    typedef struct packed {
        logic [7:0] start_cmd;
        logic [7:0] end_cmd;
        logic       end_valid;
        logic [2:0] naddr;
        logic       release_ce;
        logic       ecc_last;
    } access_t;

    function automatic logic is_data_phase(logic [ADDR_W-1:0] a);
        return a[PHASE_BIT];
    endfunction

    function automatic access_t decode_access(logic [ADDR_W-1:0] a);
        access_t r;
        r.start_cmd  = a[10:3];
        r.end_cmd    = a[18:11];
        r.end_valid  = a[ENDV_BIT];
        r.naddr      = a[PHASE_BIT] ? 3'd0 : a[23:21];
        r.release_ce = a[PHASE_BIT] & a[REL_BIT];
        r.ecc_last   = a[PHASE_BIT] & a[LAST_BIT];
        return r;
    endfunction

endpackage

// File: rtl/nand_strobe_timer.sv
module nand_strobe_timer
    import nand_seq_pkg::*;
#(
    parameter int LOW_CYC  = 2,
    parameter int HIGH_CYC = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic strobe_low,
    output logic sample,
    output logic done
);
    localparam int MAXC = (LOW_CYC > HIGH_CYC) ? LOW_CYC : HIGH_CYC;
    localparam int CW   = $clog2(MAXC + 1);

    strobe_phase_t phase;
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= T_IDLE;
            cnt   <= '0;
        end else begin
            case (phase)
                T_IDLE:  if (start) phase <= T_SETUP;
                T_SETUP: begin
                    phase <= T_LOW;
                    cnt   <= CW'(LOW_CYC - 1);
                end
                T_LOW: begin
                    if (cnt == '0) begin
                        phase <= T_HIGH;
                        cnt   <= CW'(HIGH_CYC - 1);
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                default: begin
                    if (cnt == '0) phase <= T_IDLE;
                    else           cnt   <= cnt - 1'b1;
                end
            endcase
        end
    end

    assign strobe_low = (phase == T_LOW);
    assign sample     = (phase == T_LOW)  && (cnt == '0);
    assign done       = (phase == T_HIGH) && (cnt == '0);

    // a new strobe may only be launched once the previous one has finished
    assert_launch_when_idle_R9: assert property (@(posedge clk) disable iff (rst)
        start |-> (phase == T_IDLE));

endmodule

// File: rtl/nand_ready_wait.sv
module nand_ready_wait #(
    parameter int MIN_WAIT = 2,
    parameter int LIMIT    = 1000
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic rdy,
    output logic done,
    output logic expired
);
    localparam int CW = $clog2(LIMIT + 1);

    logic          active;
    logic [CW-1:0] cnt;
    logic          ready_seen;
    logic          at_limit;

    assign ready_seen = (cnt >= CW'(MIN_WAIT)) && rdy;
    assign at_limit   = (cnt == CW'(LIMIT - 1));
    assign done       = active && (ready_seen || at_limit);
    assign expired    = active && at_limit && !ready_seen;

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= 1'b0;
            cnt    <= '0;
        end else if (start) begin
            active <= 1'b1;
            cnt    <= '0;
        end else if (active) begin
            if (done) active <= 1'b0;
            else      cnt    <= cnt + 1'b1;
        end
    end

    assert_expire_only_busy_R10: assert property (@(posedge clk) disable iff (rst)
        expired |-> !rdy || (cnt < CW'(MIN_WAIT)));

endmodule

// File: rtl/nand_phase_seq.sv
module nand_phase_seq
    import nand_seq_pkg::*;
#(
    parameter int NUM_CE  = 4,
    parameter int T_LOW   = 2,
    parameter int T_HIGH  = 2,
    parameter int WB_MIN  = 2,
    parameter int TIMEOUT = 1000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [31:0]       req_addr,
    input  logic [31:0]       req_wdata,
    output logic              rsp_valid,
    output logic [7:0]        rsp_rdata,
    output logic              nand_cle,
    output logic              nand_ale,
    output logic [NUM_CE-1:0] nand_ce_n,
    output logic              nand_we_n,
    output logic              nand_re_n,
    output logic [7:0]        nand_io_out,
    output logic              nand_io_oe,
    input  logic [7:0]        nand_io_in,
    input  logic              nand_rdy,
    output logic              ecc_valid,
    output logic [7:0]        ecc_byte,
    output logic              ecc_last,
    output logic              busy_timeout
);
    localparam int SELW = (NUM_CE > 1) ? $clog2(NUM_CE) : 1;

    seq_state_t      state;
    access_t         acc;
    logic            go;
    logic            is_write;
    logic [7:0]      wbyte;
    logic [31:0]     addr_word;
    logic [2:0]      addr_idx;
    logic [7:0]      rd_byte;
    logic [SELW-1:0] ce_sel;
    logic            ce_active;

    logic t_low, t_sample, t_done;
    logic w_done, w_expired;
    logic reading;

    logic unused_addr_bits;
    assign unused_addr_bits = ^{req_addr[2:0], req_addr[31:CHIP_LSB+SELW]};

    nand_strobe_timer #(.LOW_CYC(T_LOW), .HIGH_CYC(T_HIGH)) u_strobe (
        .clk(clk), .rst(rst),
        .start(go && (state != S_BUSY)),
        .strobe_low(t_low), .sample(t_sample), .done(t_done)
    );

    nand_ready_wait #(.MIN_WAIT(WB_MIN), .LIMIT(TIMEOUT)) u_wait (
        .clk(clk), .rst(rst),
        .start(go && (state == S_BUSY)),
        .rdy(nand_rdy), .done(w_done), .expired(w_expired)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state        <= S_IDLE;
            acc          <= '0;
            go           <= 1'b0;
            is_write     <= 1'b0;
            wbyte        <= '0;
            addr_word    <= '0;
            addr_idx     <= '0;
            rd_byte      <= '0;
            ce_sel       <= '0;
            ce_active    <= 1'b0;
            rsp_valid    <= 1'b0;
            rsp_rdata    <= '0;
            ecc_valid    <= 1'b0;
            ecc_byte     <= '0;
            ecc_last     <= 1'b0;
            busy_timeout <= 1'b0;
        end else begin
            go           <= 1'b0;
            rsp_valid    <= 1'b0;
            ecc_valid    <= 1'b0;
            ecc_last     <= 1'b0;
            busy_timeout <= 1'b0;
            case (state)
                S_IDLE: if (req_valid) begin
                    acc       <= decode_access(req_addr);
                    is_write  <= req_write;
                    wbyte     <= req_wdata[7:0];
                    addr_word <= req_wdata;
                    addr_idx  <= '0;
                    ce_sel    <= req_addr[CHIP_LSB +: SELW];
                    ce_active <= 1'b1;
                    go        <= 1'b1;
                    state     <= is_data_phase(req_addr) ? S_DATA : S_START;
                end
                S_START: if (t_done) begin
                    if (acc.naddr != 3'd0) begin
                        state <= S_ADDR;
                        go    <= 1'b1;
                    end else if (acc.end_valid) begin
                        state <= S_END;
                        go    <= 1'b1;
                    end else begin
                        state <= S_FIN;
                    end
                end
                S_ADDR: if (t_done) begin
                    addr_idx  <= addr_idx + 3'd1;
                    addr_word <= addr_word >> 8;
                    if (addr_idx + 3'd1 == acc.naddr) begin
                        state <= acc.end_valid ? S_END : S_FIN;
                        go    <= acc.end_valid;
                    end else if (addr_idx == 3'd3) begin
                        state <= S_WORD2;
                    end else begin
                        go <= 1'b1;
                    end
                end
                S_WORD2: if (req_valid) begin
                    addr_word <= req_wdata;
                    state     <= S_ADDR;
                    go        <= 1'b1;
                end
                S_DATA: begin
                    if (t_sample && !is_write) rd_byte <= nand_io_in;
                    if (t_done) begin
                        ecc_valid <= 1'b1;
                        ecc_byte  <= is_write ? wbyte : rd_byte;
                        ecc_last  <= acc.ecc_last;
                        if (!is_write) begin
                            rsp_valid <= 1'b1;
                            rsp_rdata <= rd_byte;
                        end
                        state <= acc.end_valid ? S_END : S_FIN;
                        go    <= acc.end_valid;
                    end
                end
                S_END: if (t_done) begin
                    state <= S_BUSY;
                    go    <= 1'b1;
                end
                S_BUSY: if (w_done) begin
                    busy_timeout <= w_expired;
                    state        <= S_FIN;
                end
                default: begin
                    if (acc.release_ce) ce_active <= 1'b0;
                    state <= S_IDLE;
                end
            endcase
        end
    end

    assign reading     = (state == S_DATA) && !is_write;
    assign req_ready   = (state == S_IDLE) || (state == S_WORD2);
    assign nand_cle    = (state == S_START) || (state == S_END);
    assign nand_ale    = (state == S_ADDR);
    assign nand_we_n   = !(t_low && !reading);
    assign nand_re_n   = !(t_low && reading);
    assign nand_io_oe  = nand_cle || nand_ale || ((state == S_DATA) && is_write);

    always_comb begin
        case (state)
            S_START: nand_io_out = acc.start_cmd;
            S_END:   nand_io_out = acc.end_cmd;
            S_ADDR:  nand_io_out = addr_word[7:0];
            default: nand_io_out = wbyte;
        endcase
    end

    for (genvar i = 0; i < NUM_CE; i++) begin : g_ce
        assign nand_ce_n[i] = !(ce_active && (ce_sel == SELW'(i)));
    end

    assert_one_chip_R7: assert property (@(posedge clk) disable iff (rst)
        $onehot0(~nand_ce_n));

    assert_strobe_has_chip_R7: assert property (@(posedge clk) disable iff (rst)
        (!nand_we_n || !nand_re_n) |-> ($countones(~nand_ce_n) == 1));

    assert_setup_before_fall_R9: assert property (@(posedge clk) disable iff (rst)
        $fell(nand_we_n) |-> ($stable(nand_io_out) && $stable(nand_cle) && $stable(nand_ale)));

    assert_latches_exclusive_R5: assert property (@(posedge clk) disable iff (rst)
        !(nand_cle && nand_ale));

    assert_no_dual_strobe_R6: assert property (@(posedge clk) disable iff (rst)
        !(!nand_we_n && !nand_re_n));

    assert_last_with_valid_R8: assert property (@(posedge clk) disable iff (rst)
        ecc_last |-> ecc_valid);

endmodule

// File: tb/nand_phase_seq_tb.sv
module nand_phase_seq_tb;

    localparam int NUM_CE  = 4;
    localparam int T_LOW   = 2;
    localparam int T_HIGH  = 1;
    localparam int WB_MIN  = 2;
    localparam int TIMEOUT = 300;
    localparam int LOGN    = 256;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #10 clk = ~clk;

    logic              req_valid = 1'b0;
    logic              req_ready;
    logic              req_write = 1'b0;
    logic [31:0]       req_addr  = '0;
    logic [31:0]       req_wdata = '0;
    logic              rsp_valid;
    logic [7:0]        rsp_rdata;
    logic              nand_cle, nand_ale, nand_we_n, nand_re_n, nand_io_oe;
    logic [NUM_CE-1:0] nand_ce_n;
    logic [7:0]        nand_io_out;
    logic [7:0]        nand_io_in = 8'h00;
    logic              nand_rdy   = 1'b1;
    logic              ecc_valid, ecc_last, busy_timeout;
    logic [7:0]        ecc_byte;

    nand_phase_seq #(.NUM_CE(NUM_CE), .T_LOW(T_LOW), .T_HIGH(T_HIGH),
                     .WB_MIN(WB_MIN), .TIMEOUT(TIMEOUT)) u_dut (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .nand_cle(nand_cle), .nand_ale(nand_ale), .nand_ce_n(nand_ce_n),
        .nand_we_n(nand_we_n), .nand_re_n(nand_re_n),
        .nand_io_out(nand_io_out), .nand_io_oe(nand_io_oe), .nand_io_in(nand_io_in),
        .nand_rdy(nand_rdy),
        .ecc_valid(ecc_valid), .ecc_byte(ecc_byte), .ecc_last(ecc_last),
        .busy_timeout(busy_timeout)
    );

    int n_chk = 0;
    int n_fail = 0;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // ---------------- bus monitor (negedge sampling) ----------------
    logic [7:0] lg_io  [LOGN];
    bit         lg_cle [LOGN];
    bit         lg_ale [LOGN];
    bit         lg_rd  [LOGN];
    int         lg_ce  [LOGN];
    int         lg_n = 0;
    int         width_err = 0;
    int         setup_err = 0;
    int         tmo_cnt = 0;
    int         ecc_cnt = 0;
    logic [7:0] ecc_seen_b = '0;
    bit         ecc_seen_l = 1'b0;
    int         rsp_cnt = 0;
    logic [7:0] rsp_seen = '0;

    bit         p_strobe = 1'b0;
    bit         p_cle = 1'b0, p_ale = 1'b0;
    logic [7:0] p_io = '0;
    int         lowcnt = 0;

    function automatic int ce_index(logic [NUM_CE-1:0] v);
        for (int i = 0; i < NUM_CE; i++) if (!v[i]) return i;
        return 99;
    endfunction

    always @(negedge clk) begin
        bit strobe;
        strobe = !nand_we_n || !nand_re_n;
        if (!rst) begin
            if (strobe) lowcnt++;
            if (strobe && !p_strobe) begin
                if (nand_we_n == 1'b0 && (nand_cle != p_cle || nand_ale != p_ale || nand_io_out != p_io))
                    setup_err++;
                if (lg_n < LOGN) begin
                    lg_io[lg_n]  = nand_io_out;
                    lg_cle[lg_n] = nand_cle;
                    lg_ale[lg_n] = nand_ale;
                    lg_rd[lg_n]  = !nand_re_n;
                    lg_ce[lg_n]  = ce_index(nand_ce_n);
                    lg_n++;
                end
            end
            if (!strobe && p_strobe) begin
                if (lowcnt != T_LOW) width_err++;
                lowcnt = 0;
            end
            if (busy_timeout) tmo_cnt++;
            if (ecc_valid) begin
                ecc_cnt++;
                ecc_seen_b = ecc_byte;
                ecc_seen_l = ecc_last;
            end
            if (rsp_valid) begin
                rsp_cnt++;
                rsp_seen = rsp_rdata;
            end
        end
        p_strobe = strobe;
        p_cle    = nand_cle;
        p_ale    = nand_ale;
        p_io     = nand_io_out;
    end

    // ---------------- host tasks ----------------
    task automatic send(input logic [31:0] a, input logic [31:0] d, input bit w);
        @(negedge clk);
        req_valid = 1'b1;
        req_addr  = a;
        req_wdata = d;
        req_write = w;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic wait_idle(output int cycles);
        cycles = 0;
        do begin
            @(negedge clk);
            cycles++;
        end while (!req_ready && cycles < 5000);
    endtask

    function automatic logic [31:0] cmd_addr(input logic [1:0] chip, input logic [2:0] na,
                                             input bit ev, input logic [7:0] endc,
                                             input logic [7:0] st);
        return {6'b0, chip, na, ev, 1'b0, endc, st, 3'b000};
    endfunction

    // ---------------- stimulus table ----------------
    typedef struct packed {
        logic [1:0]  chip;
        logic [7:0]  st;
        logic [7:0]  en;
        logic        ev;
        logic [2:0]  na;
        logic [31:0] w1;
        logic [31:0] w2;
    } vec_t;

    localparam vec_t VECS [6] = '{
        '{2'd0, 8'h00, 8'h30, 1'b1, 3'd5, 32'h44332211, 32'h00000055},
        '{2'd1, 8'h90, 8'h00, 1'b0, 3'd1, 32'h000000AB, 32'h00000000},
        '{2'd2, 8'hFF, 8'h00, 1'b0, 3'd0, 32'h00000000, 32'h00000000},
        '{2'd3, 8'h80, 8'h10, 1'b1, 3'd7, 32'h04030201, 32'h00070605},
        '{2'd0, 8'h70, 8'h00, 1'b0, 3'd0, 32'h00000000, 32'h00000000},
        '{2'd1, 8'h60, 8'hD0, 1'b1, 3'd3, 32'h00C0B0A0, 32'h00000000}
    };

    function automatic logic [7:0] addr_byte(input vec_t v, input int k);
        return (k < 4) ? v.w1[8*k +: 8] : v.w2[8*(k-4) +: 8];
    endfunction

    // ---------------- watchdog ----------------
    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog (R10 run hung) actual=%0d expected=%0d", 200000, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    // ---------------- main sequence ----------------
    initial begin
        int base, cyc, exp_n;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1: reset state
        chk(nand_ce_n == '1, "R1 chip enables", 32'(nand_ce_n), 32'hF);
        chk(nand_we_n && nand_re_n, "R1 strobes", {30'b0, nand_we_n, nand_re_n}, 32'h3);
        chk(!nand_cle && !nand_ale, "R1 latches", {30'b0, nand_cle, nand_ale}, 32'h0);
        chk(req_ready == 1'b1, "R1 req_ready", 32'(req_ready), 32'h1);

        // table walk: R2 R3 R4 R5 R7
        for (int v = 0; v < 6; v++) begin
            base = lg_n;
            send(cmd_addr(VECS[v].chip, VECS[v].na, VECS[v].ev, VECS[v].en, VECS[v].st),
                 VECS[v].w1, 1'b1);
            if (VECS[v].na > 3'd4) send(32'h0, VECS[v].w2, 1'b1);   // R4 second word
            wait_idle(cyc);
            exp_n = 1 + int'(VECS[v].na) + (VECS[v].ev ? 1 : 0);
            chk(lg_n - base == exp_n, "R3 strobe count", 32'(lg_n - base), 32'(exp_n));
            chk(lg_cle[base] && !lg_ale[base] && lg_io[base] == VECS[v].st,
                "R2 start opcode", {23'b0, lg_cle[base], lg_io[base]}, {23'b0, 1'b1, VECS[v].st});
            for (int k = 0; k < int'(VECS[v].na); k++)
                chk(lg_ale[base+1+k] && !lg_cle[base+1+k] && lg_io[base+1+k] == addr_byte(VECS[v], k),
                    (k >= 4) ? "R4 spilled address byte" : "R3 address byte",
                    {23'b0, lg_ale[base+1+k], lg_io[base+1+k]}, {23'b0, 1'b1, addr_byte(VECS[v], k)});
            if (VECS[v].ev)
                chk(lg_cle[base+exp_n-1] && lg_io[base+exp_n-1] == VECS[v].en, "R5 closing opcode",
                    {23'b0, lg_cle[base+exp_n-1], lg_io[base+exp_n-1]}, {23'b0, 1'b1, VECS[v].en});
            chk(lg_ce[base] == int'(VECS[v].chip), "R7 chip select", 32'(lg_ce[base]), 32'(VECS[v].chip));
            chk(ce_index(nand_ce_n) == int'(VECS[v].chip), "R7 enable held after command",
                32'(ce_index(nand_ce_n)), 32'(VECS[v].chip));
        end

        // data write, closing opcode, release, ecc last: R6 R5 R7 R8
        base = lg_n;
        send((32'h1 << 21) | (32'h1 << 20) | (32'h1 << 19) | (32'h10 << 11) | (32'h1 << 10),
             32'h0000005A, 1'b1);
        wait_idle(cyc);
        chk(lg_n - base == 2, "R6 write strobe count", 32'(lg_n - base), 32'd2);
        chk(!lg_rd[base] && !lg_cle[base] && !lg_ale[base] && lg_io[base] == 8'h5A, "R6 write byte",
            32'(lg_io[base]), 32'h5A);
        chk(lg_cle[base+1] && lg_io[base+1] == 8'h10, "R5 closing opcode after data",
            32'(lg_io[base+1]), 32'h10);
        chk(ecc_seen_b == 8'h5A && ecc_seen_l, "R8 ecc byte with last",
            {23'b0, ecc_seen_l, ecc_seen_b}, {23'b0, 1'b1, 8'h5A});
        chk(nand_ce_n == '1, "R7 release after data", 32'(nand_ce_n), 32'hF);

        // data read on chip 2, no release: R6 R7 R8
        nand_io_in = 8'hC3;
        base = lg_n;
        send((32'h2 << 24) | (32'h1 << 19), 32'h0, 1'b0);
        wait_idle(cyc);
        chk(lg_n - base == 1 && lg_rd[base], "R6 read strobe", 32'(lg_n - base), 32'd1);
        chk(rsp_seen == 8'hC3 && rsp_cnt == 1, "R6 read data", 32'(rsp_seen), 32'hC3);
        chk(ecc_seen_b == 8'hC3 && !ecc_seen_l, "R8 ecc byte not last",
            {23'b0, ecc_seen_l, ecc_seen_b}, {23'b0, 1'b0, 8'hC3});
        chk(nand_ce_n == 4'b1011, "R7 enable kept after read", 32'(nand_ce_n), 32'hB);

        // R10: hold busy across a closing opcode, then release
        nand_rdy = 1'b0;
        send(cmd_addr(2'd0, 3'd0, 1'b1, 8'hD0, 8'h70), 32'h0, 1'b1);
        repeat (60) @(negedge clk);
        chk(req_ready == 1'b0, "R10 held while busy", 32'(req_ready), 32'h0);
        nand_rdy = 1'b1;
        repeat (6) @(negedge clk);
        chk(req_ready == 1'b1, "R10 resumes on ready", 32'(req_ready), 32'h1);
        chk(tmo_cnt == 0, "R10 no timeout when ready", 32'(tmo_cnt), 32'h0);

        // R10: timeout
        nand_rdy = 1'b0;
        send(cmd_addr(2'd0, 3'd0, 1'b1, 8'hD0, 8'h70), 32'h0, 1'b1);
        wait_idle(cyc);
        chk(tmo_cnt == 1, "R10 timeout pulse", 32'(tmo_cnt), 32'h1);
        chk(cyc >= TIMEOUT && cyc <= TIMEOUT + 30, "R10 timeout length", 32'(cyc), 32'(TIMEOUT));

        // R11: no closing opcode, busy line ignored
        send(cmd_addr(2'd1, 3'd1, 1'b0, 8'h00, 8'h05), 32'h77, 1'b1);
        wait_idle(cyc);
        chk(cyc <= 30, "R11 no wait without closing opcode", 32'(cyc), 32'd30);
        nand_rdy = 1'b1;

        // R9: strobe widths and setup across the whole run
        chk(width_err == 0, "R9 strobe low width", 32'(width_err), 32'h0);
        chk(setup_err == 0, "R9 setup before strobe", 32'(setup_err), 32'h0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

endmodule